// File: doc/BRIEF.md
# Compact 16-bit Harvard Microcontroller Core

This block is a small sequencer-style processor. It fetches one 16-bit instruction word per instruction from a synchronous program memory and decodes it into one of a few dozen operation classes. It then executes the instruction against a file of sixteen 16-bit registers. Program, data and I/O each have their own port. Data memory can only be read. The I/O space can be read, written, cleared, set, and have single bits set or cleared through a read-modify-write. Every address counts 16-bit words. Every operand field names the source first and the destination second.

Control flow uses absolute targets only. These are conditional branches on a zero flag and a sign flag, plain and register-indirect jumps, and subroutine calls backed by an internal return stack. A count-down loop instruction uses r0 as its counter. A wait instruction parks the core until the interrupt-request input goes high. The core is a five-state machine:
- FETCH presents the program counter to the program memory.
- EXEC decodes the returned word and either completes it or hands over to another state.
- LOAD writes a data-memory word into a register.
- IORD finishes an I/O read or an I/O bit update.
- SLEEP holds the core until the interrupt request arrives.

The transitions are:
- FETCH→EXEC always.
- EXEC→FETCH for every single-step instruction.
- EXEC→LOAD for data loads.
- EXEC→IORD for I/O input and I/O bit set or clear.
- EXEC→SLEEP for wait.
- LOAD→FETCH, IORD→FETCH and SLEEP→FETCH once irq is high.

Top module: `hmc16_core`

## Requirements
- R1: ALU format `000 fff m sssss dddd` computes dst = dst op src, with fff 000 or, 001 and, 010 xor, 011 test (and, no write), 100 move, 101 add, 110 subtract (dst minus src), 111 compare (subtract, no write). With m=1 the source is the 5-bit field zero-extended. With m=0 the source is register sssss[3:0] when sssss[4]=0, or the instruction's own address when sssss=10000. Every ALU op sets Z (result zero) and N (result bit 15).
- R2: Shift format `0011 fff m ssss dddd`, with fff 000 left logical, 100 right logical, 110 right arithmetic. The amount is ssss when m=1, or the low 4 bits of register ssss when m=0. Z and N follow the result.
- R3: Bit format `0010 c 000 iiii dddd`: c=0 tests bit iiii of dst, setting Z when that bit is 0 and leaving dst unchanged. c=1 clears that bit in dst.
- R4: `0100 cc tttttttttt` branches to absolute t when the condition holds (cc 00 Z=1, 01 Z=0, 10 N=1, 11 N=0), otherwise it continues at the next word.
- R5: `011000 t10` jumps to t. `0110 1100 0000 dddd` jumps to the address held in register d.
- R6: `011001 t10` pushes the next address onto an 8-entry return stack and jumps to t. 0x7000 pops the stack and returns there, so calls nest eight deep.
- R7: `011010 t10` decrements r0 and branches to t when the decremented value is nonzero.
- R8: `11 iiiiiiiiii dddd` writes the 10-bit immediate, zero-extended, into dst.
- R9: `0111 1 aaaaaaa dddd` loads data word a into dst. `0110 1111 ssss dddd` loads the data word addressed by register s into dst.
- R10: `1000 aaaaaaaa dddd` reads I/O address a into dst. `1001 aaaaaaaa ssss` writes register s to I/O address a. `0110 1110 ssss dddd` writes register s to the I/O address held in register d.
- R11: `0111 0010 aaaaaaaa` writes 0x0000 to I/O address a, and `0111 0011 aaaaaaaa` writes 0xFFFF. `1010 aaaaaaaa bbbb` clears bit b and `1011 aaaaaaaa bbbb` sets bit b of I/O address a, keeping its other bits.
- R12: 0x7100 holds the program counter and drives no memory or I/O strobe until irq is high, then resumes at the next word.
- R13: Encodings outside the listed formats (for example group 0101) and 0x0000 leave every register unchanged.
- R14: Reset clears the program counter, all registers and both flags, so the first fetch is from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Interrupt request that releases a wait |
| imem_addr | output | 10 | Program-memory word address |
| imem_rdata | input | 16 | Program word, one cycle after the address |
| dmem_re | output | 1 | Data-memory read strobe |
| dmem_addr | output | DMEM_AW | Data-memory word address |
| dmem_rdata | input | 16 | Data word, one cycle after the strobe |
| io_re | output | 1 | I/O read strobe |
| io_we | output | 1 | I/O write strobe |
| io_addr | output | 8 | I/O address |
| io_wdata | output | 16 | I/O write data |
| io_rdata | input | 16 | I/O read data, one cycle after the strobe |

## Verification
Register, flag and stack state is hidden, so the bench makes every result visible by writing it to the I/O port. A wrong register value, a wrong flag or a wrong return address therefore shows as a wrong word at a known I/O address, no later than the next output instruction, which runs a few cycles after the faulty one. A wrong program counter shows at once on the program-memory address, either as a skipped output or as a result that lands out of order. While the core waits, the bench watches the program address and the strobes for twenty cycles to check that nothing moves.

// File: rtl/hmc16_pkg.sv
package hmc16_pkg;

    localparam int XLEN   = 16;
    localparam int NREG   = 16;
    localparam int RIDX_W = $clog2(NREG);
    localparam int PC_W   = 10;
    localparam int IO_AW  = 8;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_EXEC,
        ST_LOAD,
        ST_IORD,
        ST_SLEEP
    } core_state_e;

    typedef enum logic [4:0] {
        CL_NOP, CL_ALU, CL_BTST, CL_BCLR, CL_SHIFT,
        CL_BR, CL_JMP, CL_JSR, CL_LOOP, CL_JMPR, CL_RTS, CL_WAIT,
        CL_LMDR, CL_LMDA, CL_IN, CL_OUT, CL_OUTR,
        CL_OCLR, CL_OSET, CL_OBCLR, CL_OBSET, CL_LLI
    } insn_class_e;

    localparam logic [2:0] FN_OR  = 3'b000;
    localparam logic [2:0] FN_AND = 3'b001;
    localparam logic [2:0] FN_XOR = 3'b010;
    localparam logic [2:0] FN_TST = 3'b011;
    localparam logic [2:0] FN_MOV = 3'b100;
    localparam logic [2:0] FN_ADD = 3'b101;
    localparam logic [2:0] FN_SUB = 3'b110;
    localparam logic [2:0] FN_CMP = 3'b111;

    localparam logic [2:0] SH_LL  = 3'b000;
    localparam logic [2:0] SH_RL  = 3'b100;
    localparam logic [2:0] SH_RA  = 3'b110;

    function automatic insn_class_e decode_insn(input logic [15:0] ir);
        insn_class_e c;
        c = CL_NOP;
        casez (ir[15:12])
            4'b000?: c = (!ir[9] && ir[8] && (ir[7:4] != 4'd0)) ? CL_NOP : CL_ALU;
            4'b0010: c = ir[11] ? CL_BCLR : CL_BTST;
            4'b0011: c = (ir[11:9] == SH_LL || ir[11:9] == SH_RL || ir[11:9] == SH_RA)
                         ? CL_SHIFT : CL_NOP;
            4'b0100: c = CL_BR;
            4'b0110: begin
                case (ir[11:10])
                    2'b00: c = CL_JMP;
                    2'b01: c = CL_JSR;
                    2'b10: c = CL_LOOP;
                    default: begin
                        case (ir[9:8])
                            2'b00:   c = (ir[7:4] == 4'd0) ? CL_JMPR : CL_NOP;
                            2'b10:   c = CL_OUTR;
                            2'b11:   c = CL_LMDR;
                            default: c = CL_NOP;
                        endcase
                    end
                endcase
            end
            4'b0111: begin
                if (ir[11]) begin
                    c = CL_LMDA;
                end else begin
                    case (ir[10:8])
                        3'b000:  c = (ir[7:0] == 8'd0) ? CL_RTS  : CL_NOP;
                        3'b001:  c = (ir[7:0] == 8'd0) ? CL_WAIT : CL_NOP;
                        3'b010:  c = CL_OCLR;
                        3'b011:  c = CL_OSET;
                        default: c = CL_NOP;
                    endcase
                end
            end
            4'b1000: c = CL_IN;
            4'b1001: c = CL_OUT;
            4'b1010: c = CL_OBCLR;
            4'b1011: c = CL_OBSET;
            4'b11??: c = CL_LLI;
            default: c = CL_NOP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hmc16_regfile.sv
module hmc16_regfile
    import hmc16_pkg::*;
#(
    parameter int W = XLEN,
    parameter int N = NREG
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [$clog2(N)-1:0] ra_idx,
    input  logic [$clog2(N)-1:0] rb_idx,
    output logic [W-1:0]         ra_data,
    output logic [W-1:0]         rb_data,
    output logic [W-1:0]         r0_data,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] wr_idx,
    input  logic [W-1:0]         wr_data
);

    logic [W-1:0] regs_q [N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                regs_q[i] <= '0;
            end
        end else if (we) begin
            regs_q[wr_idx] <= wr_data;
        end
    end

    assign ra_data = regs_q[ra_idx];
    assign rb_data = regs_q[rb_idx];
    assign r0_data = regs_q[0];

endmodule

// File: rtl/hmc16_retstack.sv
module hmc16_retstack #(
    parameter int AW    = 10,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] top
);

    // DEPTH is a power of two so the pointer wraps on overflow and underflow.
    localparam int PTR_W = $clog2(DEPTH);

    logic [AW-1:0]    stk_q [DEPTH];
    logic [PTR_W-1:0] sp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (push) begin
            stk_q[sp_q] <= din;
            sp_q        <= sp_q + 1'b1;
        end else if (pop) begin
            sp_q <= sp_q - 1'b1;
        end
    end

    assign top = stk_q[sp_q - 1'b1];

    // R6: a pushed return address is the next one popped
    a_r6_push_then_top: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (top == $past(din)));

endmodule

// File: rtl/hmc16_alu.sv
module hmc16_alu
    import hmc16_pkg::*;
(
    input  insn_class_e      cls,
    input  logic [2:0]       fn,
    input  logic [XLEN-1:0]  src,
    input  logic [XLEN-1:0]  dst,
    output logic [XLEN-1:0]  y,
    output logic             z,
    output logic             n,
    output logic             wr_en,
    output logic             fl_en
);

    logic [3:0]      amt;
    logic [XLEN-1:0] bit_mask;

    assign amt      = src[3:0];
    assign bit_mask = {{(XLEN-1){1'b0}}, 1'b1} << amt;

    always_comb begin
        y     = dst;
        wr_en = 1'b0;
        fl_en = 1'b0;
        unique case (cls)
            CL_ALU: begin
                fl_en = 1'b1;
                wr_en = (fn != FN_TST) && (fn != FN_CMP);
                unique case (fn)
                    FN_OR:           y = dst | src;
                    FN_AND, FN_TST:  y = dst & src;
                    FN_XOR:          y = dst ^ src;
                    FN_MOV:          y = src;
                    FN_ADD:          y = dst + src;
                    FN_SUB, FN_CMP:  y = dst - src;
                    default:         y = dst;
                endcase
            end
            CL_SHIFT: begin
                fl_en = 1'b1;
                wr_en = 1'b1;
                if (fn == SH_LL)      y = dst << amt;
                else if (fn == SH_RL) y = dst >> amt;
                else                  y = $unsigned($signed(dst) >>> amt);
            end
            CL_BTST: begin
                fl_en = 1'b1;
            end
            CL_BCLR: begin
                wr_en = 1'b1;
                y     = dst & ~bit_mask;
            end
            default: ;
        endcase
    end

    always_comb begin
        if (cls == CL_BTST) begin
            z = ((dst & bit_mask) == '0);
            n = ~z;
        end else begin
            z = (y == '0);
            n = y[XLEN-1];
        end
    end

endmodule

// File: rtl/hmc16_core.sv
module hmc16_core
    import hmc16_pkg::*;
#(
    parameter int RS_DEPTH = 8,
    parameter int DMEM_AW  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq,
    output logic [PC_W-1:0]    imem_addr,
    input  logic [XLEN-1:0]    imem_rdata,
    output logic               dmem_re,
    output logic [DMEM_AW-1:0] dmem_addr,
    input  logic [XLEN-1:0]    dmem_rdata,
    output logic               io_re,
    output logic               io_we,
    output logic [IO_AW-1:0]   io_addr,
    output logic [XLEN-1:0]    io_wdata,
    input  logic [XLEN-1:0]    io_rdata
);

    localparam int ABS_W = 7;

    core_state_e      state_q, state_d;
    logic [PC_W-1:0]  pc_q, pc_d, pc_inc, tgt;
    logic             z_q, z_d, n_q, n_d;
    logic [XLEN-1:0]  ir_q, ir;
    insn_class_e      cls;

    logic [XLEN-1:0]   ra_data, rb_data, r0_data, r0_dec;
    logic              rf_we;
    logic [RIDX_W-1:0] rf_widx;
    logic [XLEN-1:0]   rf_wdata;

    logic             rs_push, rs_pop;
    logic [PC_W-1:0]  rs_top;

    logic [XLEN-1:0]  alu_src, alu_y, io_mask;
    logic             alu_z, alu_n, alu_wr, alu_fl, br_take;

    assign ir      = (state_q == ST_EXEC) ? imem_rdata : ir_q;
    assign cls     = decode_insn(ir);
    assign pc_inc  = pc_q + 1'b1;
    assign tgt     = ir[PC_W-1:0];
    assign r0_dec  = r0_data - 1'b1;
    assign io_mask = {{(XLEN-1){1'b0}}, 1'b1} << ir[3:0];
    assign imem_addr = pc_q;

    always_comb begin
        unique case (ir[11:10])
            2'b00:   br_take =  z_q;
            2'b01:   br_take = !z_q;
            2'b10:   br_take =  n_q;
            default: br_take = !n_q;
        endcase
    end

    always_comb begin
        if (cls == CL_ALU) begin
            if (ir[9])      alu_src = {{(XLEN-5){1'b0}}, ir[8:4]};
            else if (ir[8]) alu_src = {{(XLEN-PC_W){1'b0}}, pc_q};
            else            alu_src = ra_data;
        end else if (cls == CL_SHIFT && !ir[8]) begin
            alu_src = ra_data;
        end else begin
            alu_src = {{(XLEN-4){1'b0}}, ir[7:4]};
        end
    end

    hmc16_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (ir[7:4]),
        .rb_idx  (ir[3:0]),
        .ra_data (ra_data),
        .rb_data (rb_data),
        .r0_data (r0_data),
        .we      (rf_we),
        .wr_idx  (rf_widx),
        .wr_data (rf_wdata)
    );

    hmc16_retstack #(.AW(PC_W), .DEPTH(RS_DEPTH)) u_rs (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rs_push),
        .pop   (rs_pop),
        .din   (pc_inc),
        .top   (rs_top)
    );

    hmc16_alu u_alu (
        .cls   (cls),
        .fn    (cls == CL_SHIFT ? ir[11:9] : ir[12:10]),
        .src   (alu_src),
        .dst   (rb_data),
        .y     (alu_y),
        .z     (alu_z),
        .n     (alu_n),
        .wr_en (alu_wr),
        .fl_en (alu_fl)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            z_q  <= 1'b0;
            n_q  <= 1'b0;
            ir_q <= '0;
        end else begin
            pc_q <= pc_d;
            z_q  <= z_d;
            n_q  <= n_d;
            if (state_q == ST_EXEC) ir_q <= imem_rdata;
        end
    end

    always_comb begin
        state_d   = state_q;
        pc_d      = pc_q;
        z_d       = z_q;
        n_d       = n_q;
        rf_we     = 1'b0;
        rf_widx   = ir[3:0];
        rf_wdata  = alu_y;
        rs_push   = 1'b0;
        rs_pop    = 1'b0;
        dmem_re   = 1'b0;
        dmem_addr = '0;
        io_re     = 1'b0;
        io_we     = 1'b0;
        io_addr   = ir[11:4];
        io_wdata  = '0;
        unique case (state_q)
            ST_FETCH: state_d = ST_EXEC;
            ST_EXEC: begin
                state_d = ST_FETCH;
                pc_d    = pc_inc;
                unique case (cls)
                    CL_ALU, CL_SHIFT, CL_BTST, CL_BCLR: begin
                        rf_we = alu_wr;
                        if (alu_fl) begin
                            z_d = alu_z;
                            n_d = alu_n;
                        end
                    end
                    CL_BR:   if (br_take) pc_d = tgt;
                    CL_JMP:  pc_d = tgt;
                    CL_JSR: begin
                        rs_push = 1'b1;
                        pc_d    = tgt;
                    end
                    CL_LOOP: begin
                        rf_we    = 1'b1;
                        rf_widx  = '0;
                        rf_wdata = r0_dec;
                        if (r0_dec != '0) pc_d = tgt;
                    end
                    CL_JMPR: pc_d = rb_data[PC_W-1:0];
                    CL_RTS: begin
                        rs_pop = 1'b1;
                        pc_d   = rs_top;
                    end
                    CL_WAIT: begin
                        pc_d    = pc_q;
                        state_d = ST_SLEEP;
                    end
                    CL_LMDR, CL_LMDA: begin
                        dmem_re   = 1'b1;
                        dmem_addr = (cls == CL_LMDR) ? ra_data[DMEM_AW-1:0]
                                  : {{(DMEM_AW-ABS_W){1'b0}}, ir[10:4]};
                        pc_d      = pc_q;
                        state_d   = ST_LOAD;
                    end
                    CL_IN, CL_OBCLR, CL_OBSET: begin
                        io_re   = 1'b1;
                        pc_d    = pc_q;
                        state_d = ST_IORD;
                    end
                    CL_OUT: begin
                        io_we    = 1'b1;
                        io_wdata = rb_data;
                    end
                    CL_OUTR: begin
                        io_we    = 1'b1;
                        io_addr  = rb_data[IO_AW-1:0];
                        io_wdata = ra_data;
                    end
                    CL_OCLR, CL_OSET: begin
                        io_we    = 1'b1;
                        io_addr  = ir[7:0];
                        io_wdata = (cls == CL_OSET) ? '1 : '0;
                    end
                    CL_LLI: begin
                        rf_we    = 1'b1;
                        rf_wdata = {{(XLEN-10){1'b0}}, ir[13:4]};
                    end
                    default: ;
                endcase
            end
            ST_LOAD: begin
                rf_we    = 1'b1;
                rf_wdata = dmem_rdata;
                pc_d     = pc_inc;
                state_d  = ST_FETCH;
            end
            ST_IORD: begin
                if (cls == CL_IN) begin
                    rf_we    = 1'b1;
                    rf_wdata = io_rdata;
                end else begin
                    io_we    = 1'b1;
                    io_wdata = (cls == CL_OBSET) ? (io_rdata | io_mask)
                                                 : (io_rdata & ~io_mask);
                end
                pc_d    = pc_inc;
                state_d = ST_FETCH;
            end
            ST_SLEEP: begin
                if (irq) begin
                    pc_d    = pc_inc;
                    state_d = ST_FETCH;
                end
            end
            default: state_d = ST_FETCH;
        endcase
    end

    // R12: the program counter does not move while parked without irq
    a_r12_wait_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && !irq) |=> $stable(pc_q));

    // R12: no strobe leaves the core while it is parked
    a_r12_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP) |-> (!io_we && !io_re && !dmem_re));

    // R5: an absolute jump lands on the word's target field
    a_r5_jmp_target: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && cls == CL_JMP) |=> (pc_q == $past(imem_rdata[PC_W-1:0])));

    // R7: loop lowers r0 by exactly one
    a_r7_loop_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && cls == CL_LOOP) |=> (r0_data == $past(r0_data) - 16'd1));

    // R11: read and write strobes never coincide on the I/O port
    a_r11_io_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_we && io_re));

endmodule

// File: tb/hmc16_core_bench.sv
module hmc16_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic [9:0]  imem_addr;
    logic [15:0] imem_rdata = '0;
    logic        dmem_re;
    logic [15:0] dmem_addr;
    logic [15:0] dmem_rdata = '0;
    logic        io_re, io_we;
    logic [7:0]  io_addr;
    logic [15:0] io_wdata;
    logic [15:0] io_rdata = '0;

    always #10 clk = ~clk;   // 50 MHz

    hmc16_core u_hmc16_core (
        .clk(clk), .rst_n(rst_n), .irq(irq),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_re(dmem_re), .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata),
        .io_re(io_re), .io_we(io_we), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    logic [15:0] imem   [1024];
    logic [15:0] dmem   [256];
    logic [15:0] io_mem [256];
    logic [15:0] exp_val [256];
    bit          exp_vld [256];
    string       exp_tag [256];

    int  checks = 0;
    int  fails  = 0;
    int  wp     = 0;
    int  port   = 0;
    bit  wait_seen = 0;
    bit  done_seen = 0;
    bit  finished  = 0;

    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr];
        if (dmem_re) dmem_rdata <= dmem[dmem_addr[7:0]];
        if (io_re)   io_rdata   <= io_mem[io_addr];
        if (io_we) begin
            io_mem[io_addr] <= io_wdata;
            if (io_addr == 8'hF0) wait_seen <= 1'b1;
            if (io_addr == 8'hFF) done_seen <= 1'b1;
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic emit(input logic [15:0] w);
        imem[wp] = w;
        wp++;
    endtask

    task automatic out_exp(input logic [3:0] r, input logic [15:0] v, input string tag);
        emit({4'h9, port[7:0], r});
        exp_val[port] = v;
        exp_vld[port] = 1'b1;
        exp_tag[port] = tag;
        port++;
    endtask

    function automatic logic [15:0] e_alu(input logic [2:0] f, input logic m,
                                           input logic [4:0] s, input logic [3:0] d);
        return {3'b000, f, m, s, d};
    endfunction
    function automatic logic [15:0] e_sh(input logic [2:0] f, input logic m,
                                          input logic [3:0] s, input logic [3:0] d);
        return {4'b0011, f, m, s, d};
    endfunction
    function automatic logic [15:0] e_lli(input logic [9:0] v, input logic [3:0] d);
        return {2'b11, v, d};
    endfunction
    function automatic logic [15:0] e_ctl(input logic [1:0] aa, input int t);
        return {4'b0110, aa, t[9:0]};
    endfunction
    function automatic logic [15:0] e_br(input logic [1:0] cc, input int t);
        return {4'b0100, cc, t[9:0]};
    endfunction

    function automatic logic [15:0] alu_ref(input int f, input logic [15:0] a, input logic [15:0] b);
        case (f)
            0: return b | a;
            1: return b & a;
            2: return b ^ a;
            4: return a;
            5: return b + a;
            6: return b - a;
            default: return b;
        endcase
    endfunction

    // branch body: bcc taken -> r6=2, not taken -> r6=1
    task automatic br_body(input logic [1:0] cc, input bit taken, input string tag);
        int base;
        base = wp;
        emit(e_br(cc, base + 3));
        emit(e_lli(10'd1, 4'd6));
        emit(e_ctl(2'b00, base + 4));
        emit(e_lli(10'd2, 4'd6));
        out_exp(4'd6, taken ? 16'd2 : 16'd1, tag);
    endtask

    initial begin
        logic [15:0] vals [3];
        logic [15:0] sv;
        int l;
        vals[0] = 16'h0003; vals[1] = 16'h0155; vals[2] = 16'h03FF;
        for (int i = 0; i < 1024; i++) imem[i] = 16'h0000;
        for (int i = 0; i < 256; i++) begin
            dmem[i]   = (i * 16'h0101) ^ 16'h5A00;
            io_mem[i] = '0;
            exp_vld[i] = 1'b0;
        end
        io_mem[8'hC0] = 16'hBEEF;
        io_mem[8'hD1] = 16'h1234;
        io_mem[8'hD2] = 16'h00F0;

        // R14: untouched register reads zero after reset
        out_exp(4'd13, 16'h0000, "R14");
        // R1: ALU sweep, register source
        for (int f = 0; f < 8; f++)
            for (int ai = 0; ai < 3; ai++)
                for (int bi = 0; bi < 3; bi++) begin
                    emit(e_lli(vals[ai][9:0], 4'd1));
                    emit(e_lli(vals[bi][9:0], 4'd2));
                    emit(e_alu(f[2:0], 1'b0, 5'd1, 4'd2));
                    out_exp(4'd2, alu_ref(f, vals[ai], vals[bi]), "R1");
                end
        // R1: immediate source
        emit(e_lli(10'h3FF, 4'd2)); emit(e_alu(3'b101, 1'b1, 5'h1F, 4'd2));
        out_exp(4'd2, 16'h041E, "R1");
        emit(e_lli(10'd3, 4'd2));   emit(e_alu(3'b110, 1'b1, 5'd5, 4'd2));
        out_exp(4'd2, 16'hFFFE, "R1");
        emit(e_lli(10'h100, 4'd2)); emit(e_alu(3'b000, 1'b1, 5'h11, 4'd2));
        out_exp(4'd2, 16'h0111, "R1");
        // R1: source code 10000 reads own address
        l = wp;
        emit(e_alu(3'b100, 1'b0, 5'b10000, 4'd15));
        out_exp(4'd15, l[15:0], "R1");
        // R2: shift sweep on 0xE940
        for (int k = 0; k < 3; k++)
            for (int a = 0; a < 16; a++) begin
                logic [2:0] f;
                f = (k == 0) ? 3'b000 : (k == 1) ? 3'b100 : 3'b110;
                emit(e_lli(10'h3A5, 4'd3));
                emit(e_sh(3'b000, 1'b1, 4'd6, 4'd3));
                emit(e_sh(f, 1'b1, a[3:0], 4'd3));
                sv = 16'hE940;
                if (k == 0)      sv = sv << a;
                else if (k == 1) sv = sv >> a;
                else             sv = $unsigned($signed(sv) >>> a);
                out_exp(4'd3, sv, "R2");
            end
        emit(e_lli(10'd3, 4'd4)); emit(e_lli(10'h3A5, 4'd3));
        emit(e_sh(3'b100, 1'b0, 4'd4, 4'd3));
        out_exp(4'd3, 16'h0074, "R2");
        // R4: every condition against zero, positive and negative values
        for (int cc = 0; cc < 4; cc++)
            for (int k = 0; k < 3; k++) begin
                bit zf, nf, tk;
                emit(e_lli((k == 0) ? 10'd0 : (k == 1) ? 10'd5 : 10'd1, 4'd5));
                emit(e_sh(3'b000, 1'b1, (k == 2) ? 4'd15 : 4'd0, 4'd5));
                zf = (k == 0); nf = (k == 2);
                tk = (cc == 0) ? zf : (cc == 1) ? !zf : (cc == 2) ? nf : !nf;
                br_body(cc[1:0], tk, "R4");
            end
        // R3: bit test drives Z, bit clear
        for (int k = 0; k < 4; k++) begin
            int idx;
            idx = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : 6;
            emit(e_lli(10'h0A5, 4'd5));
            emit({4'b0010, 1'b0, 3'b000, idx[3:0], 4'd5});
            br_body(2'b00, ((16'h00A5 >> idx) & 1) == 0, "R3");
        end
        emit(e_lli(10'h0A5, 4'd5)); emit({4'b0010, 1'b1, 3'b000, 4'd7, 4'd5});
        out_exp(4'd5, 16'h0025, "R3");
        emit({4'b0010, 1'b1, 3'b000, 4'd1, 4'd5});
        out_exp(4'd5, 16'h0025, "R3");
        // R7: loop five times, then once
        emit(e_lli(10'd5, 4'd0)); emit(e_lli(10'd0, 4'd7));
        l = wp; emit(e_alu(3'b101, 1'b1, 5'd3, 4'd7)); emit(e_ctl(2'b10, l));
        out_exp(4'd7, 16'd15, "R7"); out_exp(4'd0, 16'd0, "R7");
        emit(e_lli(10'd1, 4'd0)); emit(e_lli(10'd0, 4'd7));
        l = wp; emit(e_alu(3'b101, 1'b1, 5'd3, 4'd7)); emit(e_ctl(2'b10, l));
        out_exp(4'd7, 16'd3, "R7");
        // R5: register and absolute jumps
        l = wp;
        emit(e_lli(l[9:0] + 10'd3, 4'd9)); emit({8'h6C, 4'h0, 4'd9});
        emit(e_lli(10'd7, 4'd10)); emit(e_lli(10'd9, 4'd10));
        out_exp(4'd10, 16'd9, "R5");
        l = wp; emit(e_ctl(2'b00, l + 2)); emit(e_lli(10'd7, 4'd10));
        out_exp(4'd10, 16'd9, "R5");
        // R6: two-level and eight-level calls
        emit(e_ctl(2'b01, 10'h380));
        out_exp(4'd8, 16'd16, "R6");
        imem[10'h380] = e_lli(10'd10, 4'd8); imem[10'h381] = e_ctl(2'b01, 10'h390);
        imem[10'h382] = e_alu(3'b101, 1'b1, 5'd1, 4'd8); imem[10'h383] = 16'h7000;
        imem[10'h390] = e_alu(3'b101, 1'b1, 5'd5, 4'd8); imem[10'h391] = 16'h7000;
        emit(e_lli(10'd0, 4'd8)); emit(e_ctl(2'b01, 10'h3A0));
        out_exp(4'd8, 16'd15, "R6");
        for (int k = 0; k < 8; k++) begin
            int b;
            b = 10'h3A0 + 4 * k;
            imem[b] = e_alu(3'b101, 1'b1, 5'd1, 4'd8);
            if (k < 7) begin
                imem[b + 1] = e_ctl(2'b01, b + 4);
                imem[b + 2] = e_alu(3'b101, 1'b1, 5'd1, 4'd8);
                imem[b + 3] = 16'h7000;
            end else begin
                imem[b + 1] = 16'h7000;
            end
        end
        // R8: long immediate zero-extends
        emit(e_lli(10'h3FF, 4'd1)); out_exp(4'd1, 16'h03FF, "R8");
        emit(e_lli(10'h2C6, 4'd1)); out_exp(4'd1, 16'h02C6, "R8");
        // R9: data loads, absolute and register-indirect
        emit({5'b01111, 7'h05, 4'd11}); out_exp(4'd11, (16'd5 * 16'h0101) ^ 16'h5A00, "R9");
        emit({5'b01111, 7'h7F, 4'd11}); out_exp(4'd11, (16'h7F * 16'h0101) ^ 16'h5A00, "R9");
        emit(e_lli(10'h0E3, 4'd12)); emit({8'h6F, 4'd12, 4'd11});
        out_exp(4'd11, (16'hE3 * 16'h0101) ^ 16'h5A00, "R9");
        // R10: I/O input and register-addressed output
        emit({4'h8, 8'hC0, 4'd13}); out_exp(4'd13, 16'hBEEF, "R10");
        emit(e_lli(10'h0C8, 4'd12)); emit(e_lli(10'h077, 4'd1));
        emit({8'h6E, 4'd1, 4'd12});
        exp_val[8'hC8] = 16'h0077; exp_vld[8'hC8] = 1'b1; exp_tag[8'hC8] = "R10";
        // R11: whole-word and single-bit I/O updates
        emit({8'h73, 8'hD0}); emit({4'hA, 8'hD0, 4'd3});
        emit({8'h72, 8'hD1}); emit({4'hB, 8'hD1, 4'd15});
        emit({4'hB, 8'hD2, 4'd0});
        exp_val[8'hD0] = 16'hFFF7; exp_vld[8'hD0] = 1'b1; exp_tag[8'hD0] = "R11";
        exp_val[8'hD1] = 16'h8000; exp_vld[8'hD1] = 1'b1; exp_tag[8'hD1] = "R11";
        exp_val[8'hD2] = 16'h00F1; exp_vld[8'hD2] = 1'b1; exp_tag[8'hD2] = "R11";
        // R12: marker then wait
        emit({8'h73, 8'hF0}); emit(16'h7100);
        // R13: undefined words leave r14 alone
        emit(e_lli(10'h02A, 4'd14));
        emit(16'h5ABE); emit(16'h6D3E); emit(16'h7405); emit(16'h0000);
        emit(e_sh(3'b001, 1'b1, 4'd3, 4'd14));
        emit(e_alu(3'b100, 1'b0, 5'b10011, 4'd14));
        out_exp(4'd14, 16'h002A, "R13");
        emit({8'h73, 8'hFF});
        l = wp; emit(e_ctl(2'b00, l));
    end

    initial begin
        logic [9:0] held;
        bit quiet;
        repeat (3) @(negedge clk);
        check(imem_addr == 10'd0 && !io_we && !io_re && !dmem_re, "R14",
              {6'd0, imem_addr}, 16'h0000);
        rst_n = 1'b1;
        while (!wait_seen) @(negedge clk);
        repeat (4) @(negedge clk);
        held  = imem_addr;
        quiet = 1'b1;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (imem_addr != held || io_we || io_re || dmem_re) quiet = 1'b0;
        end
        check(quiet, "R12", {6'd0, imem_addr}, {6'd0, held});
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        while (!done_seen) @(negedge clk);
        repeat (2) @(negedge clk);
        for (int i = 0; i < 256; i++)
            if (exp_vld[i])
                check(io_mem[i] == exp_val[i], exp_tag[i], io_mem[i], exp_val[i]);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", imem_addr, 16'h0000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule